// File: doc/BRIEF.md
# Conditional Software Trap Unit

This block executes the conditional trap instruction of a processor with windowed registers. Each cycle that `issue` is high, it tests a 4-bit condition field against the integer condition codes. It also computes an 8-bit trap type from the operands, and decides whether a trap is raised. A higher-priority exception or interrupt that is pending in the same cycle suppresses the trap. When the condition is false, the instruction leaves every piece of state as it was, like a no-operation.

A taken trap does the following:
- forces supervisor mode and keeps the old supervisor bit in a previous-supervisor bit;
- disables traps;
- moves the current window pointer down by one, wrapping at the window count;
- places the trap type in the trap base register;
- issues one write strobe that saves PC and nPC into local registers 1 and 2 of the newly selected window.

A trap raised while traps are already disabled only pulses an error-mode flag and changes no state. A state-write path lets the surrounding pipeline load the mode bits, the window pointer and the trap base. This is how a return-from-trap would re-enable traps.

All outputs are registered. The effect of an instruction presented at one rising edge is visible right after that edge.

Top module: `swtrap_unit`

## Requirements
- R1: The condition uses `icc` = {N,Z,V,C} (bit 3 = N, bit 0 = C). Codes 0000 to 0111 give: never, Z, Z|(N^V), N^V, C|Z, C, N, V. Codes 1000 to 1111 give the complement of the code with bit 3 cleared, so 1000 means always.
- R2: An issued instruction whose condition is false raises neither `trap_taken` nor `err_mode`. It asserts no save strobe and leaves `sup`, `prev_sup`, `trap_en`, `cwp` and `tbr` unchanged.
- R3: When `hp_pending` is high in the issue cycle, no trap and no error are raised, even for a true condition.
- R4: With `imm_sel` = 0, the trap type is 0x80 plus the low 7 bits of `rs1_val + rs2_val`.
- R5: With `imm_sel` = 1, the trap type is 0x80 plus the low 7 bits of `rs1_val` plus the sign-extended `simm`. Every trap type lies in 0x80..0xFF.
- R6: A taken trap sets `sup` to 1, copies the former `sup` into `prev_sup`, and clears `trap_en`.
- R7: A taken trap sets `cwp` to the old value minus one, and from 0 it wraps to NWINDOWS-1.
- R8: A taken trap pulses `sv_we` for one cycle with `sv_win` equal to the new `cwp`, `sv_l1_data` equal to `pc` and `sv_l2_data` equal to `npc`.
- R9: `tbr` bits [31:12] hold the trap base and are kept by a trap. Bits [11:4] receive the trap type and bits [3:0] read 0.
- R10: A trap raised while `trap_en` is 0 pulses `err_mode` for one cycle and changes no state.
- R11: When no trap is raised, `wr_en` loads `sup`, `prev_sup`, `trap_en`, `cwp` and the trap base. A raised trap in the same cycle (taken or error) wins and the write is dropped.
- R12: Reset gives `sup`=1, `prev_sup`=0, `trap_en`=0, `cwp`=0, `tbr`=0 and no pulses.
- R13: `trap_taken` pulses for exactly one cycle after each issue cycle that takes a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | A trap instruction is executing this cycle |
| cond | input | 4 | Condition field |
| icc | input | 4 | Condition codes {N,Z,V,C} |
| imm_sel | input | 1 | 1: second operand is the immediate |
| rs1_val | input | XLEN | First register operand |
| rs2_val | input | XLEN | Second register operand |
| simm | input | IMM_W | Signed immediate trap number |
| pc | input | XLEN | Program counter of the instruction |
| npc | input | XLEN | Next program counter |
| hp_pending | input | 1 | Higher-priority exception or interrupt pending |
| wr_en | input | 1 | State write strobe |
| wr_sup | input | 1 | Value to load into the supervisor bit |
| wr_prev_sup | input | 1 | Value to load into the previous-supervisor bit |
| wr_trap_en | input | 1 | Value to load into the trap-enable bit |
| wr_cwp | input | CWP_W | Value to load into the window pointer |
| wr_tba | input | XLEN-12 | Value to load into the trap base |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous-supervisor bit |
| trap_en | output | 1 | Trap-enable bit |
| cwp | output | CWP_W | Current window pointer |
| tbr | output | XLEN | Trap base register |
| trap_taken | output | 1 | Pulse: trap taken |
| err_mode | output | 1 | Pulse: trap raised with traps disabled |
| sv_we | output | 1 | Save-write strobe for the new window |
| sv_win | output | CWP_W | Window the save targets |
| sv_l1_data | output | XLEN | Data for local register 1 (PC) |
| sv_l2_data | output | XLEN | Data for local register 2 (nPC) |

## Verification
A state write and a raised trap can land in the same cycle, and the trap must win. The bench provokes this by pulsing `wr_en` with distinctive load values in the issue cycle of an always-true trap. It then checks that the mode bits, window pointer and trap base follow the trap rules and not the load values. The same pairing with a never-true condition confirms that the write then lands in full.

// File: rtl/swtrap_pkg.sv
package swtrap_pkg;

    localparam logic [7:0] TT_SW_BASE = 8'h80;
    localparam int         TT_LOW_W   = 7;

    // Bit positions inside the {N,Z,V,C} condition-code vector.
    localparam int ICC_N = 3;
    localparam int ICC_Z = 2;
    localparam int ICC_V = 1;
    localparam int ICC_C = 0;

    typedef enum logic [2:0] {
        TST_NEVER = 3'd0,
        TST_EQ    = 3'd1,
        TST_LE    = 3'd2,
        TST_LT    = 3'd3,
        TST_LEU   = 3'd4,
        TST_CS    = 3'd5,
        TST_NEG   = 3'd6,
        TST_VS    = 3'd7
    } cond_test_e;

endpackage

// File: rtl/swtrap_cond.sv
module swtrap_cond
    import swtrap_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] icc,
    output logic       hit
);
    logic       base;
    logic       n_f, z_f, v_f, c_f;
    cond_test_e test;

    assign n_f  = icc[ICC_N];
    assign z_f  = icc[ICC_Z];
    assign v_f  = icc[ICC_V];
    assign c_f  = icc[ICC_C];
    assign test = cond_test_e'(cond[2:0]);

    always_comb begin
        unique case (test)
            TST_NEVER: base = 1'b0;
            TST_EQ:    base = z_f;
            TST_LE:    base = z_f | (n_f ^ v_f);
            TST_LT:    base = n_f ^ v_f;
            TST_LEU:   base = c_f | z_f;
            TST_CS:    base = c_f;
            TST_NEG:   base = n_f;
            TST_VS:    base = v_f;
            default:   base = 1'b0;
        endcase
    end

    // Upper half of the encoding space is the complement of the lower half.
    assign hit = base ^ cond[3];
endmodule

// File: rtl/swtrap_tt.sv
module swtrap_tt
    import swtrap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 13
) (
    input  logic             imm_sel,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  rs2_val,
    input  logic [IMM_W-1:0] simm,
    output logic [7:0]       tt
);
    logic [TT_LOW_W-1:0] op1_lo;
    logic [TT_LOW_W-1:0] op2_lo;
    logic [TT_LOW_W-1:0] imm_lo;
    logic [TT_LOW_W-1:0] sum_lo;

    // Only the low bits of the sum matter; carries never move downward.
    generate
        if (IMM_W >= TT_LOW_W) begin : g_imm_wide
            assign imm_lo = simm[TT_LOW_W-1:0];
        end else begin : g_imm_narrow
            assign imm_lo = TT_LOW_W'($signed(simm));
        end
    endgenerate

    assign op1_lo = rs1_val[TT_LOW_W-1:0];
    assign op2_lo = imm_sel ? imm_lo : rs2_val[TT_LOW_W-1:0];
    assign sum_lo = op1_lo + op2_lo;
    assign tt     = TT_SW_BASE | {1'b0, sum_lo};
endmodule

// File: rtl/swtrap_wdec.sv
module swtrap_wdec #(
    parameter int NWINDOWS = 8,
    parameter int CWP_W    = 3
) (
    input  logic [CWP_W-1:0] cwp_in,
    output logic [CWP_W-1:0] cwp_out
);
    localparam logic [CWP_W-1:0] TOP_WIN = CWP_W'(NWINDOWS - 1);

    generate
        if ((1 << CWP_W) == NWINDOWS) begin : g_pow2
            assign cwp_out = cwp_in - 1'b1;
        end else begin : g_wrap
            assign cwp_out = (cwp_in == '0) ? TOP_WIN : cwp_in - 1'b1;
        end
    endgenerate
endmodule

// File: rtl/swtrap_unit.sv
module swtrap_unit
    import swtrap_pkg::*;
#(
    parameter int NWINDOWS = 8,
    parameter int XLEN     = 32,
    parameter int IMM_W    = 13,
    localparam int CWP_W   = (NWINDOWS > 1) ? $clog2(NWINDOWS) : 1,
    localparam int TBA_W   = XLEN - 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        cond,
    input  logic [3:0]        icc,
    input  logic              imm_sel,
    input  logic [XLEN-1:0]   rs1_val,
    input  logic [XLEN-1:0]   rs2_val,
    input  logic [IMM_W-1:0]  simm,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   npc,
    input  logic              hp_pending,
    input  logic              wr_en,
    input  logic              wr_sup,
    input  logic              wr_prev_sup,
    input  logic              wr_trap_en,
    input  logic [CWP_W-1:0]  wr_cwp,
    input  logic [TBA_W-1:0]  wr_tba,
    output logic              sup,
    output logic              prev_sup,
    output logic              trap_en,
    output logic [CWP_W-1:0]  cwp,
    output logic [XLEN-1:0]   tbr,
    output logic              trap_taken,
    output logic              err_mode,
    output logic              sv_we,
    output logic [CWP_W-1:0]  sv_win,
    output logic [XLEN-1:0]   sv_l1_data,
    output logic [XLEN-1:0]   sv_l2_data
);
    typedef struct packed {
        logic             s;
        logic             ps;
        logic             et;
        logic [CWP_W-1:0] cwp;
        logic [TBA_W-1:0] tba;
        logic [7:0]       tt;
        logic             taken;
        logic             err;
        logic             sv_we;
        logic [CWP_W-1:0] sv_win;
        logic [XLEN-1:0]  sv_l1;
        logic [XLEN-1:0]  sv_l2;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic             cond_hit;
    logic [7:0]       tt_val;
    logic [CWP_W-1:0] cwp_dec;
    logic             raise;

    swtrap_cond i_cond (
        .cond (cond),
        .icc  (icc),
        .hit  (cond_hit)
    );

    swtrap_tt #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) i_tt (
        .imm_sel (imm_sel),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .simm    (simm),
        .tt      (tt_val)
    );

    swtrap_wdec #(
        .NWINDOWS (NWINDOWS),
        .CWP_W    (CWP_W)
    ) i_wdec (
        .cwp_in  (st_q.cwp),
        .cwp_out (cwp_dec)
    );

    assign raise = issue && cond_hit && !hp_pending;

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        st_d.err   = 1'b0;
        st_d.sv_we = 1'b0;
        if (raise) begin
            if (st_q.et) begin
                st_d.s      = 1'b1;
                st_d.ps     = st_q.s;
                st_d.et     = 1'b0;
                st_d.cwp    = cwp_dec;
                st_d.tt     = tt_val;
                st_d.taken  = 1'b1;
                st_d.sv_we  = 1'b1;
                st_d.sv_win = cwp_dec;
                st_d.sv_l1  = pc;
                st_d.sv_l2  = npc;
            end else begin
                st_d.err = 1'b1;
            end
        end else if (wr_en) begin
            st_d.s   = wr_sup;
            st_d.ps  = wr_prev_sup;
            st_d.et  = wr_trap_en;
            st_d.cwp = wr_cwp;
            st_d.tba = wr_tba;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            st_q.s <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sup        = st_q.s;
    assign prev_sup   = st_q.ps;
    assign trap_en    = st_q.et;
    assign cwp        = st_q.cwp;
    assign tbr        = {st_q.tba, st_q.tt, 4'b0000};
    assign trap_taken = st_q.taken;
    assign err_mode   = st_q.err;
    assign sv_we      = st_q.sv_we;
    assign sv_win     = st_q.sv_win;
    assign sv_l1_data = st_q.sv_l1;
    assign sv_l2_data = st_q.sv_l2;
endmodule

// File: rtl/swtrap_chk.sv
module swtrap_chk #(
    parameter int NWINDOWS = 8,
    parameter int CWP_W    = 3,
    parameter int XLEN     = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic [3:0]       cond,
    input logic             hp_pending,
    input logic             sup,
    input logic             prev_sup,
    input logic             trap_en,
    input logic [CWP_W-1:0] cwp,
    input logic [XLEN-1:12] tba_hi,
    input logic             tt_msb,
    input logic             trap_taken,
    input logic             err_mode,
    input logic             sv_we,
    input logic [CWP_W-1:0] sv_win
);
    assert_never_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && cond == 4'b0000) |=> (!trap_taken && !err_mode));

    assert_hp_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && hp_pending) |=> (!trap_taken && !err_mode));

    assert_tt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> tt_msb);

    assert_mode_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (sup && !trap_en && prev_sup == $past(sup)));

    assert_cwp_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (cwp == (($past(cwp) == '0) ? CWP_W'(NWINDOWS - 1)
                                                   : CWP_W'($past(cwp) - 1'b1))));

    assert_save_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sv_we |-> (trap_taken && sv_win == cwp));

    assert_base_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> $stable(tba_hi));

    assert_err_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> ($stable(cwp) && $stable(tba_hi) && $stable(sup) && $stable(trap_en)));

    assert_taken_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> !trap_taken);
endmodule

bind swtrap_unit swtrap_chk #(
    .NWINDOWS (NWINDOWS),
    .CWP_W    (CWP_W),
    .XLEN     (XLEN)
) i_swtrap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .cond       (cond),
    .hp_pending (hp_pending),
    .sup        (sup),
    .prev_sup   (prev_sup),
    .trap_en    (trap_en),
    .cwp        (cwp),
    .tba_hi     (tbr[XLEN-1:12]),
    .tt_msb     (tbr[11]),
    .trap_taken (trap_taken),
    .err_mode   (err_mode),
    .sv_we      (sv_we),
    .sv_win     (sv_win)
);

// File: tb/test_swtrap_unit.sv
module test_swtrap_unit;
    localparam int NW    = 8;
    localparam int XLEN  = 32;
    localparam int IMM_W = 13;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              issue, imm_sel, hp_pending;
    logic [3:0]        cond, icc;
    logic [XLEN-1:0]   rs1_val, rs2_val, pc, npc;
    logic [IMM_W-1:0]  simm;
    logic              wr_en, wr_sup, wr_prev_sup, wr_trap_en;
    logic [2:0]        wr_cwp;
    logic [19:0]       wr_tba;
    logic              sup, prev_sup, trap_en, trap_taken, err_mode, sv_we;
    logic [2:0]        cwp, sv_win;
    logic [XLEN-1:0]   tbr, sv_l1_data, sv_l2_data;

    int checks = 0;
    int errors = 0;

    // Bench model of the architectural state
    bit        m_s, m_ps, m_et;
    int        m_cwp;
    bit [19:0] m_tba;
    bit [7:0]  m_tt;

    always #5 clk = ~clk;

    swtrap_unit #(.NWINDOWS(NW), .XLEN(XLEN), .IMM_W(IMM_W)) i_swtrap_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .cond(cond), .icc(icc),
        .imm_sel(imm_sel), .rs1_val(rs1_val), .rs2_val(rs2_val), .simm(simm),
        .pc(pc), .npc(npc), .hp_pending(hp_pending), .wr_en(wr_en),
        .wr_sup(wr_sup), .wr_prev_sup(wr_prev_sup), .wr_trap_en(wr_trap_en),
        .wr_cwp(wr_cwp), .wr_tba(wr_tba), .sup(sup), .prev_sup(prev_sup),
        .trap_en(trap_en), .cwp(cwp), .tbr(tbr), .trap_taken(trap_taken),
        .err_mode(err_mode), .sv_we(sv_we), .sv_win(sv_win),
        .sv_l1_data(sv_l1_data), .sv_l2_data(sv_l2_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Condition table written out per encoding; icc = {N,Z,V,C}.
    function automatic bit cond_ref(input bit [3:0] c, input bit [3:0] f);
        bit n = f[3], z = f[2], v = f[1], cy = f[0];
        case (c)
            4'h0: return 1'b0;
            4'h1: return z;
            4'h2: return z || (n != v);
            4'h3: return n != v;
            4'h4: return cy || z;
            4'h5: return cy;
            4'h6: return n;
            4'h7: return v;
            4'h8: return 1'b1;
            4'h9: return !z;
            4'hA: return !(z || (n != v));
            4'hB: return n == v;
            4'hC: return !(cy || z);
            4'hD: return !cy;
            4'hE: return !n;
            default: return !v;
        endcase
    endfunction

    task automatic idle_inputs();
        issue = 0; cond = 0; icc = 0; imm_sel = 0; rs1_val = 0; rs2_val = 0;
        simm = 0; pc = 0; npc = 0; hp_pending = 0; wr_en = 0; wr_sup = 0;
        wr_prev_sup = 0; wr_trap_en = 0; wr_cwp = 0; wr_tba = 0;
    endtask

    task automatic check_state(input string req);
        chk({req, " sup"}, 64'(sup), 64'(m_s));
        chk({req, " prev_sup"}, 64'(prev_sup), 64'(m_ps));
        chk({req, " trap_en"}, 64'(trap_en), 64'(m_et));
        chk({req, " cwp"}, 64'(cwp), 64'(m_cwp));
        chk({req, " tbr"}, 64'(tbr), 64'({m_tba, m_tt, 4'h0}));
    endtask

    task automatic write_state(input bit s, input bit ps, input bit et,
                               input int w, input bit [19:0] base);
        @(negedge clk);
        wr_en = 1; wr_sup = s; wr_prev_sup = ps; wr_trap_en = et;
        wr_cwp = 3'(w); wr_tba = base;
        @(negedge clk);
        wr_en = 0;
        m_s = s; m_ps = ps; m_et = et; m_cwp = w; m_tba = base;
        check_state("R11 load");
    endtask

    // One issue cycle; also_wr adds a conflicting state write.
    task automatic run_trap(input bit [3:0] c, input bit [3:0] f, input bit isel,
                            input bit [31:0] a, input bit [31:0] b,
                            input bit [12:0] im, input bit hp, input bit also_wr,
                            input string req);
        bit        hit, rz, tk, er;
        bit [31:0] op2, sum, pcv, npcv;
        bit [7:0]  ttv;
        pcv  = a ^ 32'h1000_0000;
        npcv = pcv + 4;
        @(negedge clk);
        issue = 1; cond = c; icc = f; imm_sel = isel; rs1_val = a; rs2_val = b;
        simm = im; hp_pending = hp; pc = pcv; npc = npcv;
        if (also_wr) begin
            wr_en = 1; wr_sup = 0; wr_prev_sup = 1; wr_trap_en = 1;
            wr_cwp = 3'd5; wr_tba = 20'hABCDE;
        end
        @(negedge clk);
        idle_inputs();
        hit = cond_ref(c, f);
        rz  = hit && !hp;
        tk  = rz && m_et;
        er  = rz && !m_et;
        op2 = isel ? {{19{im[12]}}, im} : b;
        sum = a + op2;
        ttv = {1'b1, sum[6:0]};
        if (tk) begin
            m_ps = m_s; m_s = 1; m_et = 0;
            m_cwp = (m_cwp == 0) ? NW - 1 : m_cwp - 1;
            m_tt = ttv;
        end else if (!rz && also_wr) begin
            m_s = 0; m_ps = 1; m_et = 1; m_cwp = 5; m_tba = 20'hABCDE;
        end
        chk({req, " R13 taken"}, 64'(trap_taken), 64'(tk));
        chk({req, " R10 err"}, 64'(err_mode), 64'(er));
        chk({req, " R8 sv_we"}, 64'(sv_we), 64'(tk));
        check_state(req);
        if (tk) begin
            chk({req, " R8 win"}, 64'(sv_win), 64'(m_cwp));
            chk({req, " R8 l1"}, 64'(sv_l1_data), 64'(pcv));
            chk({req, " R8 l2"}, 64'(sv_l2_data), 64'(npcv));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        m_s = 1; m_ps = 0; m_et = 0; m_cwp = 0; m_tba = 0; m_tt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R12 reset");
        chk("R12 taken", 64'(trap_taken), 64'd0);
        chk("R12 err", 64'(err_mode), 64'd0);

        // R1 R2 R6 R7 R9: every condition against every flag set
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                write_state(f[0], f[1], 1'b1, (c + f) % NW, 20'(c * 4099 + f));
                run_trap(4'(c), 4'(f), f[1], 32'(c * 37 + f), 32'(f * 91),
                         13'(c * 300 - 2048), 1'b0, 1'b0, "R1 R2 sweep");
            end
        end

        // R4: register-register trap type over all low-bit sums
        for (int k = 0; k < 128; k++) begin
            write_state(1'b0, 1'b0, 1'b1, k % NW, 20'(k));
            run_trap(4'h8, 4'h0, 1'b0, 32'(k * 1237), 32'(32'hFFFF_FF00 + k),
                     13'd0, 1'b0, 1'b0, "R4 tt");
        end

        // R5: immediate trap type with signed immediates, incl. extremes
        for (int k = 0; k < 128; k++) begin
            write_state(1'b1, 1'b0, 1'b1, 0, 20'hFFFFF);
            run_trap(4'h8, 4'h0, 1'b1, 32'(k * 3), 32'hDEAD_BEEF,
                     13'(k * 67 - 4096), 1'b0, 1'b0, "R5 tt");
        end
        write_state(1'b1, 1'b0, 1'b1, 1, 20'h1);
        run_trap(4'h8, 4'h0, 1'b1, 32'd0, 32'd0, 13'h1FFF, 1'b0, 1'b0, "R5 minus1");
        chk("R5 tt 0xFF", 64'(tbr[11:4]), 64'hFF);

        // R7: explicit wrap from window 0
        write_state(1'b0, 1'b0, 1'b1, 0, 20'h5);
        run_trap(4'h8, 4'h0, 1'b0, 32'd1, 32'd2, 13'd0, 1'b0, 1'b0, "R7 wrap");
        chk("R7 wrap value", 64'(cwp), 64'(NW - 1));

        // R3: pending higher-priority event suppresses the trap
        for (int f = 0; f < 16; f++) begin
            write_state(1'b0, 1'b0, 1'b1, 3, 20'h77);
            run_trap(4'h8, 4'(f), 1'b0, 32'd9, 32'd9, 13'd0, 1'b1, 1'b0, "R3 hp");
        end

        // R10: trap with traps disabled, then a follow-on trap
        write_state(1'b0, 1'b1, 1'b0, 6, 20'h33);
        run_trap(4'h8, 4'h0, 1'b0, 32'd4, 32'd4, 13'd0, 1'b0, 1'b0, "R10 err");
        write_state(1'b0, 1'b0, 1'b1, 2, 20'h44);
        run_trap(4'h8, 4'h0, 1'b0, 32'd4, 32'd4, 13'd0, 1'b0, 1'b0, "R10 take");
        run_trap(4'h8, 4'h0, 1'b0, 32'd4, 32'd4, 13'd0, 1'b0, 1'b0, "R10 second");
        run_trap(4'h8, 4'h0, 1'b0, 32'd4, 32'd4, 13'd0, 1'b0, 1'b1, "R10 err+wr");

        // R11: write collides with a taken trap, and with a never trap
        write_state(1'b0, 1'b0, 1'b1, 4, 20'h12345);
        run_trap(4'h8, 4'h0, 1'b0, 32'd7, 32'd8, 13'd0, 1'b0, 1'b1, "R11 trap wins");
        chk("R11 base kept", 64'(tbr[31:12]), 64'h12345);
        run_trap(4'h0, 4'hF, 1'b0, 32'd7, 32'd8, 13'd0, 1'b0, 1'b1, "R11 write lands");
        chk("R11 cwp loaded", 64'(cwp), 64'd5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule